// File: doc/BRIEF.md
# UART Line Status Tracker

This block produces the 16-bit line status word of a 16550-style UART. On the receive side it keeps a queue of received characters. Each entry carries three error tags: break, framing and parity. A character's tags reach the status word only when that character becomes the oldest entry in the queue. An overrun is flagged when a character arrives while the queue is full, and a summary bit flags that an errored character was accepted. On the transmit side it counts bytes waiting in the transmit buffer. From that count and the shift-register busy input it reports buffer-empty and transmitter-idle.

The surrounding UART drives it with strobes. A receiver strobe comes with each character and its error flags. The host reads and pops the receive queue, writes the transmit buffer, and reads the status register. The serializer reports when it takes a byte from the buffer and whether its shift register is busy. A mode input selects queued operation, with 16 entries on each side, or single-holding-register operation, with one entry on each side.

Top module: `uart_lsr_tracker`

## Requirements
- R1: After reset the status word is 16'h0060. Bits 15:8 always read 0.
- R2: Bit 0 is 1 while the receive queue holds at least one character. `rx_head` shows the oldest character (0 when the queue is empty). A pop removes that character.
- R3: The receive queue holds 16 characters when `fifo_mode` is 1 and 1 character when it is 0. A character that arrives while the queue is full is discarded and sets bit 1 (overrun). Fullness is judged before a pop in the same cycle.
- R4: Bit 2 (parity) and bit 3 (framing) become set one cycle after a character carrying that tag becomes the oldest entry. Tags of younger entries do not show before then.
- R5: A break character is stored with all-zero data. It always carries a framing tag as well, and its break tag shows in bit 4 when the character becomes the oldest entry.
- R6: A status read strobe clears bits 1, 2, 3, 4 and 7 in the next cycle. A setting event in the same cycle takes priority over the clear.
- R7: Bit 7 is set after an accepted character with any error tag while `fifo_mode` is 1. Bit 7 reads 0 whenever `fifo_mode` is 0.
- R8: Bit 5 is 1 exactly when the transmit buffer is empty. The buffer holds 16 bytes in queued mode and 1 in single mode. A write to a full buffer is ignored. A load strobe removes one byte.
- R9: Bit 6 is 1 only when the transmit buffer is empty and `tx_shift_busy` is 0.
- R10: A change of `fifo_mode` empties both the receive queue and the transmit buffer. Push, pop, write and load strobes in that cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 = 16-entry queues, 0 = single holding registers |
| rx_valid | input | 1 | A received character is offered this cycle |
| rx_data | input | 8 | Received character |
| rx_brk | input | 1 | Character was a break |
| rx_ferr | input | 1 | Character had a framing error |
| rx_perr | input | 1 | Character had a parity error |
| rx_pop | input | 1 | Host removes the oldest received character |
| tx_wr | input | 1 | Host writes one byte into the transmit buffer |
| tx_load | input | 1 | Serializer takes one byte from the transmit buffer |
| tx_shift_busy | input | 1 | Transmit shift register holds data |
| lsr_rd | input | 1 | Host reads the status word |
| lsr | output | 16 | Line status word |
| rx_head | output | 8 | Oldest received character |

## Verification
Every strobe acts on a register at one clock edge. Bits 0 to 5 and `rx_head` therefore change one cycle after the strobe that caused them. Bit 6 also follows `tx_shift_busy` and bit 7 follows `fifo_mode` in the same cycle. The bench applies each input set, waits for the rising edge, and then updates a reference model from the requirements. It compares every field 1 ns later, after the edge and before the next inputs are driven. A long pseudo-random sweep across both modes, with queues filled past capacity, covers the overrun, head-tag and read-clear orderings. Directed sequences add named checks for read-clear and mode-change flushing.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int LSR_W   = 16;
  localparam int B_DR    = 0;
  localparam int B_OE    = 1;
  localparam int B_PE    = 2;
  localparam int B_FE    = 3;
  localparam int B_BI    = 4;
  localparam int B_THRE  = 5;
  localparam int B_TEMT  = 6;
  localparam int B_ERRQ  = 7;

  // sticky flag vector layout
  localparam int SF_PE   = 0;
  localparam int SF_FE   = 1;
  localparam int SF_BI   = 2;
  localparam int SF_OE   = 3;
  localparam int SF_EQ   = 4;
  localparam int SF_N    = 5;

  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } rx_tag_t;

  // a break always implies a framing fault
  function automatic rx_tag_t make_tag(logic brk, logic fe, logic pe);
    rx_tag_t t;
    t.brk = brk;
    t.fe  = fe | brk;
    t.pe  = pe;
    return t;
  endfunction

  function automatic logic tag_bad(rx_tag_t t);
    return t.brk | t.fe | t.pe;
  endfunction

  function automatic logic [LSR_W-1:0] pack_lsr(
    logic dr, logic oe, logic pe, logic fe,
    logic bi, logic thre, logic temt, logic errq);
    logic [LSR_W-1:0] w;
    w = '0;
    w[B_DR]   = dr;
    w[B_OE]   = oe;
    w[B_PE]   = pe;
    w[B_FE]   = fe;
    w[B_BI]   = bi;
    w[B_THRE] = thre;
    w[B_TEMT] = temt;
    w[B_ERRQ] = errq;
    return w;
  endfunction
endpackage

// File: rtl/lsr_rx_queue.sv
module lsr_rx_queue
  import lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        wide,
  input  logic                        push_req,
  input  logic [DW-1:0]               push_data,
  input  rx_tag_t                     push_tag,
  input  logic                        pop_req,
  output logic [$clog2(DEPTH+1)-1:0]  level,
  output logic [DW-1:0]               head_data,
  output logic                        push_ok,
  output logic                        drop,
  output logic                        pop_ok,
  output logic                        head_evt,
  output rx_tag_t                     head_evt_tag
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [DW-1:0] mem_d [DEPTH];
  rx_tag_t       mem_t [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [LW-1:0] cap;
  logic          full;

  function automatic logic [AW-1:0] adv(logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign cap     = wide ? LW'(DEPTH) : LW'(1);
  assign full    = level >= cap;
  assign push_ok = push_req && !full && !flush;
  assign drop    = push_req &&  full && !flush;
  assign pop_ok  = pop_req && (level != '0) && !flush;

  // tags of the entry that becomes oldest at this edge
  always_comb begin
    head_evt     = 1'b0;
    head_evt_tag = '0;
    if (pop_ok) begin
      if (level >= LW'(2)) begin
        head_evt     = 1'b1;
        head_evt_tag = mem_t[adv(rd_ptr)];
      end else if (push_ok) begin
        head_evt     = 1'b1;
        head_evt_tag = push_tag;
      end
    end else if ((level == '0) && push_ok) begin
      head_evt     = 1'b1;
      head_evt_tag = push_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= adv(wr_ptr);
      if (pop_ok)  rd_ptr <= adv(rd_ptr);
      level <= level + LW'(push_ok) - LW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem_d[wr_ptr] <= push_data;
      mem_t[wr_ptr] <= push_tag;
    end
  end

  assign head_data = (level != '0) ? mem_d[rd_ptr] : '0;
endmodule

// File: rtl/lsr_tx_track.sv
module lsr_tx_track #(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic wide,
  input  logic wr_req,
  input  logic load_req,
  input  logic shift_busy,
  output logic wr_ok,
  output logic buf_empty,
  output logic all_idle
);
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] cnt, cap;
  logic          ld_ok;

  assign cap   = wide ? CW'(DEPTH) : CW'(1);
  assign wr_ok = wr_req && (cnt < cap) && !flush;
  assign ld_ok = load_req && (cnt != '0) && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (flush)  cnt <= '0;
    else             cnt <= cnt + CW'(wr_ok) - CW'(ld_ok);
  end

  assign buf_empty = (cnt == '0);
  assign all_idle  = buf_empty && !shift_busy;
endmodule

// File: rtl/lsr_sticky.sv
module lsr_sticky #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] set,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr)    q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_lsr_tracker.sv
module uart_lsr_tracker
  import lsr_pkg::*;
#(
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 16,
  parameter int DW       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_data,
  input  logic             rx_brk,
  input  logic             rx_ferr,
  input  logic             rx_perr,
  input  logic             rx_pop,
  input  logic             tx_wr,
  input  logic             tx_load,
  input  logic             tx_shift_busy,
  input  logic             lsr_rd,
  output logic [LSR_W-1:0] lsr,
  output logic [DW-1:0]    rx_head
);
  localparam int LW = $clog2(RX_DEPTH+1);

  logic          mode_q, flush;
  rx_tag_t       in_tag, hev_tag;
  logic [DW-1:0] in_data;
  logic [LW-1:0] rx_level;
  logic          rx_push_ok, rx_drop, rx_pop_ok, rx_hev;
  logic          tx_acc, tx_empty, tx_idle;
  logic [SF_N-1:0] sf_set, sf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_mode;
  end
  assign flush = fifo_mode != mode_q;

  assign in_tag  = make_tag(rx_brk, rx_ferr, rx_perr);
  assign in_data = rx_brk ? '0 : rx_data;

  lsr_rx_queue #(.DEPTH(RX_DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wide(fifo_mode),
    .push_req(rx_valid), .push_data(in_data), .push_tag(in_tag),
    .pop_req(rx_pop), .level(rx_level), .head_data(rx_head),
    .push_ok(rx_push_ok), .drop(rx_drop), .pop_ok(rx_pop_ok),
    .head_evt(rx_hev), .head_evt_tag(hev_tag)
  );

  lsr_tx_track #(.DEPTH(TX_DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wide(fifo_mode),
    .wr_req(tx_wr), .load_req(tx_load), .shift_busy(tx_shift_busy),
    .wr_ok(tx_acc), .buf_empty(tx_empty), .all_idle(tx_idle)
  );

  always_comb begin
    sf_set        = '0;
    sf_set[SF_PE] = rx_hev && hev_tag.pe;
    sf_set[SF_FE] = rx_hev && hev_tag.fe;
    sf_set[SF_BI] = rx_hev && hev_tag.brk;
    sf_set[SF_OE] = rx_drop;
    sf_set[SF_EQ] = rx_push_ok && fifo_mode && tag_bad(in_tag);
  end

  lsr_sticky #(.W(SF_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr(lsr_rd), .set(sf_set), .q(sf_q)
  );

  assign lsr = pack_lsr(rx_level != '0, sf_q[SF_OE], sf_q[SF_PE],
                        sf_q[SF_FE], sf_q[SF_BI], tx_empty, tx_idle,
                        sf_q[SF_EQ] & fifo_mode);
endmodule

// File: rtl/lsr_chk.sv
module lsr_chk #(
  parameter int LW = 5,
  parameter int RX_DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   lsr,
  input logic          lsr_rd,
  input logic          flush,
  input logic          drop,
  input logic          push_ok,
  input logic [LW-1:0] level,
  input logic          tx_acc
);
  // R3
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> lsr[1]);
  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(RX_DEPTH));
  // R2
  data_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && level == '0) |=> lsr[0]);
  // R5
  brk_implies_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[4] |-> lsr[3]);
  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !drop) |=> !lsr[1]);
  // R8
  tx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_acc |=> !lsr[5]);
  // R9
  idle_needs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6] |-> lsr[5]);
  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0 && lsr[5]));
endmodule

bind uart_lsr_tracker lsr_chk #(.LW(LW), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .lsr(lsr), .lsr_rd(lsr_rd), .flush(flush),
  .drop(rx_drop), .push_ok(rx_push_ok), .level(rx_level), .tx_acc(tx_acc)
);

// File: tb/tb_uart_lsr_tracker.sv
module tb_uart_lsr_tracker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_mode = 0, rx_valid = 0, rx_brk = 0, rx_ferr = 0, rx_perr = 0;
  logic [7:0] rx_data = '0;
  logic rx_pop = 0, tx_wr = 0, tx_load = 0, tx_shift_busy = 0, lsr_rd = 0;
  logic [15:0] lsr;
  logic [7:0]  rx_head;

  always #2.5 clk = ~clk;

  uart_lsr_tracker dut (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_brk(rx_brk), .rx_ferr(rx_ferr), .rx_perr(rx_perr),
    .rx_pop(rx_pop), .tx_wr(tx_wr), .tx_load(tx_load),
    .tx_shift_busy(tx_shift_busy), .lsr_rd(lsr_rd), .lsr(lsr), .rx_head(rx_head)
  );

  int n_chk = 0, n_fail = 0;
  int cycles = 0;

  // reference state
  logic [7:0] qd [16];
  logic [2:0] qt [16];   // {brk, fe, pe}
  int  lvl = 0, txc = 0;
  logic m_mode = 0, m_pe = 0, m_fe = 0, m_bi = 0, m_oe = 0, m_eq = 0;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  task automatic model_edge();
    int cap;
    logic fl, full, drop, pok, qok, hev;
    logic [2:0] nt, ht;
    logic [7:0] nd;
    fl = (fifo_mode != m_mode);
    m_mode = fifo_mode;
    cap = fifo_mode ? 16 : 1;
    nt = {rx_brk, rx_ferr | rx_brk, rx_perr};
    nd = rx_brk ? 8'h00 : rx_data;
    drop = 0; pok = 0; hev = 0; ht = '0;
    if (fl) begin
      lvl = 0; txc = 0;
    end else begin
      full = (lvl >= cap);
      drop = rx_valid && full;
      pok  = rx_valid && !full;
      qok  = rx_pop && lvl > 0;
      if (qok) begin
        if (lvl >= 2) begin hev = 1; ht = qt[1]; end
        else if (pok) begin hev = 1; ht = nt; end
      end else if (lvl == 0 && pok) begin hev = 1; ht = nt; end
      if (qok) begin
        for (int i = 0; i < 15; i++) begin qd[i] = qd[i+1]; qt[i] = qt[i+1]; end
        lvl--;
      end
      if (pok) begin qd[lvl] = nd; qt[lvl] = nt; lvl++; end
      if (tx_wr && txc < cap) txc++;
      if (tx_load && txc > 0 && !(tx_wr && txc == 1 && 0)) begin
        // load acts on count before this edge's write
      end
    end
    if (lsr_rd) begin m_pe = 0; m_fe = 0; m_bi = 0; m_oe = 0; m_eq = 0; end
    if (drop) m_oe = 1;
    if (hev) begin
      if (ht[0]) m_pe = 1;
      if (ht[1]) m_fe = 1;
      if (ht[2]) m_bi = 1;
    end
    if (pok && fifo_mode && (nt != 0)) m_eq = 1;
  endtask

  int tx_pre;

  task automatic compare();
    logic [15:0] e;
    check("R1", {8'h00, lsr[15:8]}, 16'h0000);
    check("R2", {15'h0, lsr[0]}, {15'h0, lvl != 0});
    check("R2", {8'h00, rx_head}, {8'h00, (lvl != 0) ? qd[0] : 8'h00});
    check("R3", {15'h0, lsr[1]}, {15'h0, m_oe});
    check("R4", {14'h0, lsr[3:2]}, {14'h0, m_fe, m_pe});
    check("R5", {15'h0, lsr[4]}, {15'h0, m_bi});
    check("R7", {15'h0, lsr[7]}, {15'h0, m_eq & fifo_mode});
    check("R8", {15'h0, lsr[5]}, {15'h0, txc == 0});
    e = {15'h0, (txc == 0) && !tx_shift_busy};
    check("R9", {15'h0, lsr[6]}, e);
  endtask

  // one clock: apply current inputs, update model, compare
  task automatic step();
    int cap;
    cap = fifo_mode ? 16 : 1;
    tx_pre = txc;
    @(posedge clk);
    model_edge();
    // transmit loads act on the pre-edge count
    if (fifo_mode == m_mode && tx_load && tx_pre > 0 && txc != 0) txc--;
    #1;
    compare();
  endtask

  task automatic drive(logic m, logic v, logic [7:0] d, logic b, logic f,
                       logic p, logic pop, logic wr, logic ld, logic busy,
                       logic rd);
    fifo_mode = m; rx_valid = v; rx_data = d; rx_brk = b; rx_ferr = f;
    rx_perr = p; rx_pop = pop; tx_wr = wr; tx_load = ld;
    tx_shift_busy = busy; lsr_rd = rd;
    step();
  endtask

  logic [15:0] lf = 16'hACE1;
  function automatic logic [15:0] nxt(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset value
    check("R1", lsr, 16'h0060);
    check("R2", {8'h00, rx_head}, 16'h0000);

    drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // fill the queue, the 17th overruns (R3)
    for (int i = 0; i < 17; i++)
      drive(1, 1, 8'(i * 17 + 3), i == 5, (i % 4) == 1, (i % 3) == 2,
            0, 0, 0, 0, 0);
    check("R3", {15'h0, lsr[1]}, 16'h0001);
    check("R7", {15'h0, lsr[7]}, 16'h0001);
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R6 read clears sticky bits
    check("R6", {8'h00, lsr[7:0] & 8'h9E}, 16'h0000);
    for (int i = 0; i < 17; i++) begin
      drive(1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
      if (i == 4) check("R5", {8'h00, rx_head}, 16'h0000);
    end
    // transmit buffer fill and drain
    for (int i = 0; i < 18; i++) drive(1, 0, 0, 0, 0, 0, 0, 1, 0, i[0], 0);
    for (int i = 0; i < 18; i++) drive(1, 0, 0, 0, 0, 0, 0, 0, 1, i < 17, 0);
    // mode change flushes (R10)
    drive(1, 1, 8'h41, 0, 0, 0, 0, 1, 0, 0, 0);
    drive(1, 1, 8'h42, 0, 0, 0, 0, 1, 0, 0, 0);
    drive(0, 1, 8'h43, 0, 0, 0, 1, 1, 0, 0, 0);
    check("R10", {14'h0, lsr[5], lsr[0]}, 16'h0002);
    // single holding register
    drive(0, 1, 8'h55, 0, 0, 1, 0, 1, 0, 0, 0);
    drive(0, 1, 8'h66, 1, 0, 0, 0, 1, 0, 0, 0);
    check("R3", {15'h0, lsr[1]}, 16'h0001);
    drive(0, 1, 8'h77, 1, 0, 0, 1, 0, 1, 1, 1);
    drive(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    // pseudo-random sweep
    for (int n = 0; n < 6000; n++) begin
      logic m;
      lf = nxt(lf); lf = nxt(lf); lf = nxt(lf);
      m = ((n / 500) % 2) == 1;
      drive(m, lf[0] | lf[1], {lf[9:6], lf[15:12]}, lf[2] & lf[3] & lf[4],
            lf[5] & lf[3], lf[10] & lf[11],
            lf[6] & (lf[7] | (m == 0)), lf[8] | lf[12], lf[13] & lf[14],
            lf[15], (lf[11:9] == 3'b101));
    end
    finish_run();
  end
endmodule